// File: doc/BRIEF.md
# Overvoltage Fault Sequencer for a Multiphase Regulator

This block is the digital overvoltage supervisor of a multiphase voltage regulator controller. It receives millivolt codes for the sensed output and for the differential feedback, the programmed reference code, and four state flags: main supply valid, auxiliary supply alive, enable and soft-start in progress. Every clock it selects the trip level that fits the present operating state, compares the right voltage against it, and drives a shared three-state command for all PWM phases, a crowbar drive and a latched fault flag.

A trip pulls the PWM command to forced-low in the same cycle through a combinational path and turns on the crowbar. Once the feedback has come down to the reference level, the command moves to high impedance. It drops back to forced-low each time the overvoltage returns. The fault latch keeps normal switching off. Only a falling edge of enable or of the supply-valid flag releases it. Reprogramming the reference never does.

Top module: `ovp_fault_seq`

## Requirements
- R1: While reset is asserted, and right after it, the PWM command reads 00 (normal), the crowbar is 0 and the fault flag is 0.
- R2: With supply invalid and the auxiliary supply alive, a trip happens when the sensed output exceeds 1800 mV (strictly greater).
- R3: With supply invalid and the auxiliary supply dead, no input value causes a trip.
- R4: With supply valid, enable low and no fault latched, a trip happens when the differential feedback exceeds 1700 mV, whatever the reference is.
- R5: With supply valid, enable high, soft-start active and no fault latched, the trip level is the larger of 1500 mV and reference + 200 mV.
- R6: With supply valid, enable high and soft-start done, the trip level is reference + 200 mV, computed without wrap-around (a reference of 4000 gives 4200, which no 12-bit code can exceed).
- R7: In the cycle of a trip, the PWM command is 01 (forced low) and the crowbar is 1, with no clock edge in between.
- R8: After a trip the command stays 01 while the feedback is above the reference. From the first cycle in which the feedback is at or below the reference, it reads 10 (high impedance) one clock later.
- R9: In high impedance, a fresh trip returns the command to 01 in the same cycle, and the 01 to 10 sequence then repeats.
- R10: The fault flag reads 1 from the clock after a trip. While it is 1, the crowbar stays 1, the command is never 00, and the trip level is reference + 200 mV in every supply-valid state.
- R11: The latch, the crowbar and the command return to 00/0/0 one clock after a cycle in which enable falls or supply-valid falls. A change of the reference code leaves them unchanged.
- R12: If a trip and a clearing edge fall in the same cycle, the trip wins: the fault flag stays 1 and the command stays 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsen_mv | input | 12 | Sensed output voltage, mV |
| vdiff_mv | input | 12 | Differential feedback voltage, mV |
| ref_mv | input | 12 | Programmed reference, mV |
| supply_ok | input | 1 | Main supply valid |
| aux_alive | input | 1 | Auxiliary supply alive |
| enable | input | 1 | Enable conditions met |
| softstart | input | 1 | Soft-start ramp in progress |
| pwm_cmd | output | 2 | 00 normal, 01 forced low, 10 high impedance |
| crowbar | output | 1 | Crowbar drive |
| fault_latched | output | 1 | Overvoltage fault latch |

## Verification
The sequence runs through every operating state with the selected voltage exactly at the trip level and one millivolt above it. This shows that the comparison is strict and that the state picked the right threshold. In the pre-enable case the feedback sits between reference + 200 and 1700, and during soft-start the reference is moved so that first the floor and then the reference decides the level; this separates the state-dependent levels. Recovery patterns hold the feedback above, at and below the reference, repeat the overvoltage, and change the reference or toggle enable and supply while latched. These show the release timing, the recurring forced-low, which events clear the latch, and which side wins when a trip and a clearing edge coincide.

// File: rtl/ovp_pkg.sv
package ovp_pkg;

  // Arithmetic width for threshold math; wide enough for any code plus margin.
  localparam int unsigned CALC_W = 16;

  typedef enum logic [1:0] {
    PWM_RUN = 2'b00,
    PWM_LOW = 2'b01,
    PWM_HIZ = 2'b10
  } pwm_cmd_e;

  typedef enum logic [2:0] {
    MODE_OFF     = 3'd0,
    MODE_AUX     = 3'd1,
    MODE_LATCHED = 3'd2,
    MODE_PRE_EN  = 3'd3,
    MODE_SOFT    = 3'd4,
    MODE_RUN     = 3'd5
  } ovp_mode_e;

  // Reference plus margin, never wrapping.
  function automatic logic [CALC_W-1:0] ref_plus_margin(
    input logic [CALC_W-1:0] ref_code,
    input logic [CALC_W-1:0] margin
  );
    return ref_code + margin;
  endfunction

  function automatic logic [CALC_W-1:0] larger_of(
    input logic [CALC_W-1:0] a,
    input logic [CALC_W-1:0] b
  );
    return (a > b) ? a : b;
  endfunction

  function automatic logic exceeds(
    input logic [CALC_W-1:0] sense,
    input logic [CALC_W-1:0] limit
  );
    return sense > limit;
  endfunction

  // Feedback has come down to the reference level.
  function automatic logic at_or_below(
    input logic [CALC_W-1:0] sense,
    input logic [CALC_W-1:0] level
  );
    return sense <= level;
  endfunction

endpackage

// File: rtl/ovp_thresh_sel.sv
module ovp_thresh_sel
  import ovp_pkg::*;
#(
  parameter int unsigned MV_W        = 12,
  parameter int unsigned AUX_TRIP_MV = 1800,
  parameter int unsigned PRE_TRIP_MV = 1700,
  parameter int unsigned SS_FLOOR_MV = 1500,
  parameter int unsigned MARGIN_MV   = 200
) (
  input  logic                supply_ok,
  input  logic                aux_alive,
  input  logic                enable,
  input  logic                softstart,
  input  logic                latched,
  input  logic [MV_W-1:0]     vsen_mv,
  input  logic [MV_W-1:0]     vdiff_mv,
  input  logic [MV_W-1:0]     ref_mv,
  output ovp_mode_e           mode,
  output logic [CALC_W-1:0]   thr_mv,
  output logic                trip
);

  localparam int unsigned PAD_W = CALC_W - MV_W;
  localparam logic [CALC_W-1:0] AUX_LIM   = CALC_W'(AUX_TRIP_MV);
  localparam logic [CALC_W-1:0] PRE_LIM   = CALC_W'(PRE_TRIP_MV);
  localparam logic [CALC_W-1:0] SS_FLOOR  = CALC_W'(SS_FLOOR_MV);
  localparam logic [CALC_W-1:0] MARGIN    = CALC_W'(MARGIN_MV);

  logic [CALC_W-1:0] vsen_x, vdiff_x, ref_x, ref_hi, sense_x;

  assign vsen_x  = {{PAD_W{1'b0}}, vsen_mv};
  assign vdiff_x = {{PAD_W{1'b0}}, vdiff_mv};
  assign ref_x   = {{PAD_W{1'b0}}, ref_mv};
  assign ref_hi  = ref_plus_margin(ref_x, MARGIN);

  // Operating state; the earlier test has priority.
  always_comb begin
    if (!supply_ok)     mode = aux_alive ? MODE_AUX : MODE_OFF;
    else if (latched)   mode = MODE_LATCHED;
    else if (!enable)   mode = MODE_PRE_EN;
    else if (softstart) mode = MODE_SOFT;
    else                mode = MODE_RUN;
  end

  always_comb begin
    unique case (mode)
      MODE_AUX:    thr_mv = AUX_LIM;
      MODE_PRE_EN: thr_mv = PRE_LIM;
      MODE_SOFT:   thr_mv = larger_of(SS_FLOOR, ref_hi);
      MODE_OFF:    thr_mv = '1;
      default:     thr_mv = ref_hi;
    endcase
  end

  // The auxiliary detector watches the output; the main one the feedback.
  assign sense_x = (mode == MODE_AUX) ? vsen_x : vdiff_x;
  assign trip    = (mode != MODE_OFF) && exceeds(sense_x, thr_mv);

endmodule

// File: rtl/ovp_clear_det.sv
module ovp_clear_det (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic supply_ok,
  output logic clear_evt
);

  logic en_q, sup_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sup_q <= 1'b0;
    end else begin
      en_q  <= enable;
      sup_q <= supply_ok;
    end
  end

  // A falling edge on either flag asks for the latch to clear.
  assign clear_evt = (en_q && !enable) || (sup_q && !supply_ok);

endmodule

// File: rtl/ovp_resp_fsm.sv
module ovp_resp_fsm
  import ovp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     trip,
  input  logic     clear_evt,
  input  logic     released,
  output pwm_cmd_e state_q,
  output pwm_cmd_e pwm_cmd,
  output logic     crowbar,
  output logic     fault_latched
);

  pwm_cmd_e state_d;
  logic     latch_d;

  always_comb begin
    state_d = state_q;
    latch_d = fault_latched;
    if (trip) begin
      state_d = PWM_LOW;
      latch_d = 1'b1;
    end else if (clear_evt) begin
      state_d = PWM_RUN;
      latch_d = 1'b0;
    end else if (state_q == PWM_LOW && released) begin
      state_d = PWM_HIZ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= PWM_RUN;
      fault_latched <= 1'b0;
    end else begin
      state_q       <= state_d;
      fault_latched <= latch_d;
    end
  end

  // Trip overrides the registered command without waiting for an edge.
  assign pwm_cmd = trip ? PWM_LOW : state_q;
  assign crowbar = trip || fault_latched;

  p_trip_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trip |-> (pwm_cmd == PWM_LOW && crowbar));

  p_latch_after_trip_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> fault_latched);

  p_no_run_while_latched_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_latched |-> (pwm_cmd != PWM_RUN && crowbar));

  p_release_to_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PWM_LOW && released && !trip && !clear_evt) |=> state_q == PWM_HIZ);

  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_evt && !trip) |=> (!fault_latched && pwm_cmd == PWM_RUN || trip));

  p_trip_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_evt && trip) |=> fault_latched);

  p_legal_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_cmd != 2'b11);

endmodule

// File: rtl/ovp_fault_seq.sv
module ovp_fault_seq
  import ovp_pkg::*;
#(
  parameter int unsigned MV_W        = 12,
  parameter int unsigned AUX_TRIP_MV = 1800,
  parameter int unsigned PRE_TRIP_MV = 1700,
  parameter int unsigned SS_FLOOR_MV = 1500,
  parameter int unsigned MARGIN_MV   = 200
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [MV_W-1:0] vsen_mv,
  input  logic [MV_W-1:0] vdiff_mv,
  input  logic [MV_W-1:0] ref_mv,
  input  logic            supply_ok,
  input  logic            aux_alive,
  input  logic            enable,
  input  logic            softstart,
  output logic [1:0]      pwm_cmd,
  output logic            crowbar,
  output logic            fault_latched
);

  localparam int unsigned PAD_W = CALC_W - MV_W;

  ovp_mode_e         mode;
  logic [CALC_W-1:0] thr_mv;
  logic              trip;
  logic              clear_evt;
  logic              released;
  pwm_cmd_e          state_q;
  pwm_cmd_e          cmd_e;

  ovp_thresh_sel #(
    .MV_W(MV_W), .AUX_TRIP_MV(AUX_TRIP_MV), .PRE_TRIP_MV(PRE_TRIP_MV),
    .SS_FLOOR_MV(SS_FLOOR_MV), .MARGIN_MV(MARGIN_MV)
  ) u_thr (
    .supply_ok(supply_ok), .aux_alive(aux_alive), .enable(enable),
    .softstart(softstart), .latched(fault_latched),
    .vsen_mv(vsen_mv), .vdiff_mv(vdiff_mv), .ref_mv(ref_mv),
    .mode(mode), .thr_mv(thr_mv), .trip(trip)
  );

  ovp_clear_det u_clr (
    .clk(clk), .rst_n(rst_n), .enable(enable), .supply_ok(supply_ok),
    .clear_evt(clear_evt)
  );

  assign released = at_or_below({{PAD_W{1'b0}}, vdiff_mv}, {{PAD_W{1'b0}}, ref_mv});

  ovp_resp_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .trip(trip), .clear_evt(clear_evt),
    .released(released), .state_q(state_q), .pwm_cmd(cmd_e),
    .crowbar(crowbar), .fault_latched(fault_latched)
  );

  assign pwm_cmd = cmd_e;

  p_dead_aux_no_trip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!supply_ok && !aux_alive) |-> !trip);

  p_aux_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!supply_ok && aux_alive && vsen_mv <= MV_W'(AUX_TRIP_MV)) |-> !trip);

  p_pre_en_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && !enable && !fault_latched && vdiff_mv > MV_W'(PRE_TRIP_MV))
      |-> pwm_cmd == 2'b01);

  p_hiz_needs_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_cmd == 2'b10) |-> fault_latched);

  p_mode_matches_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && fault_latched) |-> mode == MODE_LATCHED);

endmodule

// File: tb/ovp_fault_seq_bench.sv
module ovp_fault_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] vsen_mv = '0, vdiff_mv = '0, ref_mv = '0;
  logic        supply_ok = 1'b0, aux_alive = 1'b0, enable = 1'b0, softstart = 1'b0;
  logic [1:0]  pwm_cmd;
  logic        crowbar, fault_latched;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  ovp_fault_seq u_ovp_fault_seq (
    .clk(clk), .rst_n(rst_n), .vsen_mv(vsen_mv), .vdiff_mv(vdiff_mv),
    .ref_mv(ref_mv), .supply_ok(supply_ok), .aux_alive(aux_alive),
    .enable(enable), .softstart(softstart), .pwm_cmd(pwm_cmd),
    .crowbar(crowbar), .fault_latched(fault_latched)
  );

  // {req[4], sup aux en ss, vsen[12], vdiff[12], ref[12], pwm[2], crowbar, fault}
  localparam int NV = 35;
  localparam logic [47:0] VEC [NV] = '{
    {4'd6,  4'b1110, 12'd0,    12'd1000, 12'd1000, 2'b00, 1'b0, 1'b0}, // R6 idle
    {4'd6,  4'b1110, 12'd0,    12'd1200, 12'd1000, 2'b00, 1'b0, 1'b0}, // R6 at level
    {4'd7,  4'b1110, 12'd0,    12'd1201, 12'd1000, 2'b01, 1'b1, 1'b0}, // R7 trip
    {4'd8,  4'b1110, 12'd0,    12'd1100, 12'd1000, 2'b01, 1'b1, 1'b1}, // R8 above ref
    {4'd8,  4'b1110, 12'd0,    12'd1000, 12'd1000, 2'b01, 1'b1, 1'b1}, // R8 at ref
    {4'd8,  4'b1110, 12'd0,    12'd900,  12'd1000, 2'b10, 1'b1, 1'b1}, // R8 hiz
    {4'd9,  4'b1110, 12'd0,    12'd1150, 12'd1000, 2'b10, 1'b1, 1'b1}, // R9 no recur
    {4'd9,  4'b1110, 12'd0,    12'd1250, 12'd1000, 2'b01, 1'b1, 1'b1}, // R9 recur
    {4'd9,  4'b1110, 12'd0,    12'd950,  12'd1000, 2'b01, 1'b1, 1'b1}, // R9 held low
    {4'd11, 4'b1110, 12'd0,    12'd950,  12'd1500, 2'b10, 1'b1, 1'b1}, // R11 ref change
    {4'd11, 4'b1110, 12'd0,    12'd950,  12'd1000, 2'b10, 1'b1, 1'b1}, // R11 ref back
    {4'd11, 4'b1100, 12'd0,    12'd950,  12'd1000, 2'b10, 1'b1, 1'b1}, // R11 enable falls
    {4'd4,  4'b1100, 12'd0,    12'd1650, 12'd1000, 2'b00, 1'b0, 1'b0}, // R4 cleared, below
    {4'd4,  4'b1100, 12'd0,    12'd1700, 12'd1000, 2'b00, 1'b0, 1'b0}, // R4 at level
    {4'd4,  4'b1100, 12'd0,    12'd1701, 12'd1000, 2'b01, 1'b1, 1'b0}, // R4 trip
    {4'd10, 4'b1100, 12'd0,    12'd1300, 12'd1000, 2'b01, 1'b1, 1'b1}, // R10 latched
    {4'd10, 4'b1100, 12'd0,    12'd1000, 12'd1000, 2'b01, 1'b1, 1'b1}, // R10 at ref
    {4'd10, 4'b1100, 12'd0,    12'd1201, 12'd1000, 2'b01, 1'b1, 1'b1}, // R10 ref+200 rule
    {4'd11, 4'b1110, 12'd0,    12'd1000, 12'd1000, 2'b01, 1'b1, 1'b1}, // R11 rise no clear
    {4'd8,  4'b1110, 12'd0,    12'd1000, 12'd1000, 2'b10, 1'b1, 1'b1}, // R8 hiz
    {4'd11, 4'b0110, 12'd0,    12'd0,    12'd1000, 2'b10, 1'b1, 1'b1}, // R11 supply falls
    {4'd2,  4'b0110, 12'd1800, 12'd0,    12'd1000, 2'b00, 1'b0, 1'b0}, // R2 at level
    {4'd2,  4'b0110, 12'd1801, 12'd0,    12'd1000, 2'b01, 1'b1, 1'b0}, // R2 trip
    {4'd10, 4'b1110, 12'd0,    12'd500,  12'd1000, 2'b01, 1'b1, 1'b1}, // R10 latched
    {4'd8,  4'b1110, 12'd0,    12'd500,  12'd1000, 2'b10, 1'b1, 1'b1}, // R8 hiz
    {4'd3,  4'b0010, 12'd3000, 12'd3000, 12'd1000, 2'b10, 1'b1, 1'b1}, // R3 no trip
    {4'd3,  4'b0010, 12'd3000, 12'd3000, 12'd1000, 2'b00, 1'b0, 1'b0}, // R3 cleared
    {4'd5,  4'b1111, 12'd0,    12'd1500, 12'd1000, 2'b00, 1'b0, 1'b0}, // R5 floor level
    {4'd5,  4'b1111, 12'd0,    12'd1501, 12'd1000, 2'b01, 1'b1, 1'b0}, // R5 floor trip
    {4'd12, 4'b1101, 12'd0,    12'd1501, 12'd1000, 2'b01, 1'b1, 1'b1}, // R12 both
    {4'd12, 4'b1101, 12'd0,    12'd500,  12'd1000, 2'b01, 1'b1, 1'b1}, // R12 trip won
    {4'd8,  4'b1111, 12'd0,    12'd500,  12'd1000, 2'b10, 1'b1, 1'b1}, // R8 hiz
    {4'd11, 4'b1101, 12'd0,    12'd500,  12'd1000, 2'b10, 1'b1, 1'b1}, // R11 enable falls
    {4'd5,  4'b1111, 12'd0,    12'd1600, 12'd1400, 2'b00, 1'b0, 1'b0}, // R5 ref level
    {4'd5,  4'b1111, 12'd0,    12'd1601, 12'd1400, 2'b01, 1'b1, 1'b0}  // R5 ref trip
  };

  task automatic check(input string what, input int req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_outs(input int req, input logic [1:0] ep, input logic ec, input logic ef);
    check("pwm_cmd", req, int'(pwm_cmd), int'(ep));
    check("crowbar", req, int'(crowbar), int'(ec));
    check("fault_latched", req, int'(fault_latched), int'(ef));
  endtask

  task automatic drive(input logic [3:0] ctl, input logic [11:0] vs,
                       input logic [11:0] vd, input logic [11:0] rf);
    {supply_ok, aux_alive, enable, softstart} = ctl;
    vsen_mv = vs; vdiff_mv = vd; ref_mv = rf;
  endtask

  initial begin
    // R1: reset state
    drive(4'b1110, 12'd0, 12'd0, 12'd1000);
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check_outs(1, 2'b00, 1'b0, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][43:40], VEC[i][39:28], VEC[i][27:16], VEC[i][15:4]);
      #1;
      check_outs(int'(VEC[i][47:44]), VEC[i][3:2], VEC[i][1], VEC[i][0]);
    end

    // R1: reset in the middle of a latched fault
    @(negedge clk);
    check("latched before reset", 1, int'(fault_latched), 1);
    drive(4'b1110, 12'd0, 12'd0, 12'd1000);
    rst_n = 1'b0; #1;
    check_outs(1, 2'b00, 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    check_outs(1, 2'b00, 1'b0, 1'b0);

    // R6: reference near full scale, level 4200 cannot be exceeded
    drive(4'b1110, 12'd0, 12'd4095, 12'd4000); #1;
    check_outs(6, 2'b00, 1'b0, 1'b0);
    @(negedge clk); #1;
    check_outs(6, 2'b00, 1'b0, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule